// File: doc/BRIEF.md
# Dual-Clock Two-Port RAM with Selectable Write Output Behaviour

The block is a true two-port synchronous RAM. Port A and port B each have their own clock, clock enable, write enable, address, write data and registered read data, and either port can read or write any word. A read returns the addressed word one clock edge later through the port's output register.

Each port has a parameter that sets what its output register shows during a write cycle. In normal mode the output keeps its previous value. In write-through mode it shows the word being written. In read-first mode it shows the word the address held before the write. Read-first mode is accepted only for data widths of 9, 18 or 36 bits.

Each output register has its own active-low asynchronous reset. A shared active-low global reset clears both output registers. No reset changes the stored words. Same-address accesses on both ports in one cycle, where at least one port writes, are outside the contract.

Top module: `dpram_wm`

## Requirements
- R1: A port in normal mode (mode code WM_NORMAL) loads its output register only on a read cycle (clock enable high, write enable low), with the addressed word, one edge after the request. During a write cycle the output holds its previous value.
- R2: A port in write-through mode (WM_THROUGH) loads its output register with that port's write data on a write cycle and with the addressed word on a read cycle.
- R3: A port in read-first mode (WM_READ_FIRST) loads its output register with the word the address held before the write on a write cycle, and with the addressed word on a read cycle.
- R4: Read-first mode is legal only for a data width of 9, 18 or 36. Any other width with read-first on either port is an elaboration error.
- R5: While a port's clock enable is low, that port neither writes the memory nor changes its output register.
- R6: A read from either port returns the last data written to that address, whichever port wrote it, provided the two ports never access the same address in one cycle when either of them writes.
- R7: Driving a port's own reset (rst_a_ni or rst_b_ni) low clears that port's output register to zero at once, with no clock edge needed. The other port's output is not affected.
- R8: Driving the global reset rst_ni low clears both output registers to zero at once. They stay zero while it is held.
- R9: None of the resets alters the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Global asynchronous reset of both output registers, active low |
| clk_a_i | input | 1 | Port A clock |
| rst_a_ni | input | 1 | Port A output register asynchronous reset, active low |
| ce_a_i | input | 1 | Port A clock enable |
| we_a_i | input | 1 | Port A write enable |
| addr_a_i | input | AW | Port A word address, AW = clog2(DEPTH) |
| wdata_a_i | input | DW | Port A write data |
| rdata_a_o | output | DW | Port A registered read data |
| clk_b_i | input | 1 | Port B clock |
| rst_b_ni | input | 1 | Port B output register asynchronous reset, active low |
| ce_b_i | input | 1 | Port B clock enable |
| we_b_i | input | 1 | Port B write enable |
| addr_b_i | input | AW | Port B word address |
| wdata_b_i | input | DW | Port B write data |
| rdata_b_o | output | DW | Port B registered read data |

## Verification
The bench writes words through one port and reads them back through the other. A storage scheme that loses the other port's writes would return stale or scrambled words. It issues write cycles on ports in each of the three modes and compares the output against a behavioural model. A normal-mode port that leaks write data, or a read-first port that shows the new word in place of the old one, differs from the model on the next edge. It drops the clock enable with writes pending, and it asserts each reset between edges. This exposes writes that ignore the enable, resets that wait for a clock, resets that reach the wrong port, and resets that disturb stored words, which show up in the read-back afterwards.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;
  typedef enum logic [1:0] {
    WM_NORMAL     = 2'd0,
    WM_THROUGH    = 2'd1,
    WM_READ_FIRST = 2'd2
  } wmode_e;
endpackage

// File: rtl/dpram_bank.sv
`timescale 1ns/1ps
// One storage bank, written from a single clock domain, two combinational read taps.
module dpram_bank #(
  parameter int DW    = 18,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_x_i,
  output logic [DW-1:0] rdata_x_o,
  input  logic [AW-1:0] raddr_y_i,
  output logic [DW-1:0] rdata_y_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_x_o = mem_q[raddr_x_i];
  assign rdata_y_o = mem_q[raddr_y_i];
endmodule

// File: rtl/dpram_oreg.sv
`timescale 1ns/1ps
// Port output register; the write-cycle source is picked by MODE.
module dpram_oreg
  import dpram_pkg::*;
#(
  parameter int     DW   = 18,
  parameter wmode_e MODE = WM_NORMAL
) (
  input  logic          clk_i,
  input  logic          arst_ni,
  input  logic          ce_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] q_o
);
  logic          load;
  logic [DW-1:0] nxt;

  generate
    if (MODE == WM_NORMAL) begin : g_normal
      assign load = ce_i & ~we_i;
      assign nxt  = word_i;
    end else if (MODE == WM_THROUGH) begin : g_through
      assign load = ce_i;
      assign nxt  = we_i ? wdata_i : word_i;
    end else begin : g_read_first
      // word_i is the pre-write content because the bank updates at this edge
      assign load = ce_i;
      assign nxt  = word_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)  q_o <= '0;
    else if (load) q_o <= nxt;
  end
endmodule

// File: rtl/dpram_wm.sv
`timescale 1ns/1ps
module dpram_wm
  import dpram_pkg::*;
#(
  parameter int     DW     = 18,
  parameter int     DEPTH  = 64,
  parameter wmode_e MODE_A = WM_NORMAL,
  parameter wmode_e MODE_B = WM_NORMAL,
  localparam int    AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          rst_ni,
  input  logic          clk_a_i,
  input  logic          rst_a_ni,
  input  logic          ce_a_i,
  input  logic          we_a_i,
  input  logic [AW-1:0] addr_a_i,
  input  logic [DW-1:0] wdata_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic          clk_b_i,
  input  logic          rst_b_ni,
  input  logic          ce_b_i,
  input  logic          we_b_i,
  input  logic [AW-1:0] addr_b_i,
  input  logic [DW-1:0] wdata_b_i,
  output logic [DW-1:0] rdata_b_o
);
  localparam bit RF_USED  = (MODE_A == WM_READ_FIRST) || (MODE_B == WM_READ_FIRST);
  localparam bit RF_WIDTH = (DW == 9) || (DW == 18) || (DW == 36);

  generate
    if (RF_USED && !RF_WIDTH) begin : g_bad_width
      $error("dpram_wm: read-first mode needs a data width of 9, 18 or 36");
    end
  endgenerate

  // Each bank is owned by one clock; a word is bank_a ^ bank_b.
  logic          wr_a, wr_b;
  logic [DW-1:0] a_at_a, a_at_b, b_at_a, b_at_b;
  logic [DW-1:0] word_a, word_b;
  logic          arst_a_n, arst_b_n;

  assign wr_a = ce_a_i & we_a_i;
  assign wr_b = ce_b_i & we_b_i;

  dpram_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank_a (
    .clk_i     (clk_a_i),
    .we_i      (wr_a),
    .waddr_i   (addr_a_i),
    .wdata_i   (wdata_a_i ^ b_at_a),
    .raddr_x_i (addr_a_i),
    .rdata_x_o (a_at_a),
    .raddr_y_i (addr_b_i),
    .rdata_y_o (a_at_b)
  );

  dpram_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank_b (
    .clk_i     (clk_b_i),
    .we_i      (wr_b),
    .waddr_i   (addr_b_i),
    .wdata_i   (wdata_b_i ^ a_at_b),
    .raddr_x_i (addr_b_i),
    .rdata_x_o (b_at_b),
    .raddr_y_i (addr_a_i),
    .rdata_y_o (b_at_a)
  );

  assign word_a = a_at_a ^ b_at_a;
  assign word_b = a_at_b ^ b_at_b;

  assign arst_a_n = rst_ni & rst_a_ni;
  assign arst_b_n = rst_ni & rst_b_ni;

  dpram_oreg #(.DW(DW), .MODE(MODE_A)) u_oreg_a (
    .clk_i   (clk_a_i),
    .arst_ni (arst_a_n),
    .ce_i    (ce_a_i),
    .we_i    (we_a_i),
    .wdata_i (wdata_a_i),
    .word_i  (word_a),
    .q_o     (rdata_a_o)
  );

  dpram_oreg #(.DW(DW), .MODE(MODE_B)) u_oreg_b (
    .clk_i   (clk_b_i),
    .arst_ni (arst_b_n),
    .ce_i    (ce_b_i),
    .we_i    (we_b_i),
    .wdata_i (wdata_b_i),
    .word_i  (word_b),
    .q_o     (rdata_b_o)
  );
endmodule

// File: rtl/dpram_wm_chk.sv
`timescale 1ns/1ps
module dpram_wm_chk
  import dpram_pkg::*;
#(
  parameter int     DW     = 18,
  parameter int     DEPTH  = 64,
  parameter wmode_e MODE_A = WM_NORMAL,
  parameter wmode_e MODE_B = WM_NORMAL,
  localparam int    AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          rst_ni,
  input logic          clk_a_i,
  input logic          rst_a_ni,
  input logic          ce_a_i,
  input logic          we_a_i,
  input logic [AW-1:0] addr_a_i,
  input logic [DW-1:0] wdata_a_i,
  input logic [DW-1:0] rdata_a_o,
  input logic          clk_b_i,
  input logic          rst_b_ni,
  input logic          ce_b_i,
  input logic          we_b_i,
  input logic [AW-1:0] addr_b_i,
  input logic [DW-1:0] wdata_b_i,
  input logic [DW-1:0] rdata_b_o
);
  a_r1_normal_hold_a: assert property (@(posedge clk_a_i) disable iff (!rst_ni || !rst_a_ni)
    (MODE_A == WM_NORMAL) && ce_a_i && we_a_i |=> $stable(rdata_a_o));
  a_r1_normal_hold_b: assert property (@(posedge clk_b_i) disable iff (!rst_ni || !rst_b_ni)
    (MODE_B == WM_NORMAL) && ce_b_i && we_b_i |=> $stable(rdata_b_o));
  a_r2_through_a: assert property (@(posedge clk_a_i) disable iff (!rst_ni || !rst_a_ni)
    (MODE_A == WM_THROUGH) && ce_a_i && we_a_i |=> rdata_a_o == $past(wdata_a_i));
  a_r2_through_b: assert property (@(posedge clk_b_i) disable iff (!rst_ni || !rst_b_ni)
    (MODE_B == WM_THROUGH) && ce_b_i && we_b_i |=> rdata_b_o == $past(wdata_b_i));
  a_r5_idle_a: assert property (@(posedge clk_a_i) disable iff (!rst_ni || !rst_a_ni)
    !ce_a_i |=> $stable(rdata_a_o));
  a_r5_idle_b: assert property (@(posedge clk_b_i) disable iff (!rst_ni || !rst_b_ni)
    !ce_b_i |=> $stable(rdata_b_o));
  a_r7_port_rst_a: assert property (@(posedge clk_a_i) !rst_a_ni |-> rdata_a_o == '0);
  a_r7_port_rst_b: assert property (@(posedge clk_b_i) !rst_b_ni |-> rdata_b_o == '0);
  a_r8_global_rst: assert property (@(posedge clk_a_i) !rst_ni |-> (rdata_a_o == '0) && (rdata_b_o == '0));
endmodule

bind dpram_wm dpram_wm_chk #(
  .DW(DW), .DEPTH(DEPTH), .MODE_A(MODE_A), .MODE_B(MODE_B)
) u_chk (
  .rst_ni(rst_ni),
  .clk_a_i(clk_a_i), .rst_a_ni(rst_a_ni), .ce_a_i(ce_a_i), .we_a_i(we_a_i),
  .addr_a_i(addr_a_i), .wdata_a_i(wdata_a_i), .rdata_a_o(rdata_a_o),
  .clk_b_i(clk_b_i), .rst_b_ni(rst_b_ni), .ce_b_i(ce_b_i), .we_b_i(we_b_i),
  .addr_b_i(addr_b_i), .wdata_b_i(wdata_b_i), .rdata_b_o(rdata_b_o)
);

// File: tb/dpram_wm_tb.sv
`timescale 1ns/1ps
module dpram_wm_tb;
  import dpram_pkg::*;
  localparam int DW  = 18;
  localparam int DEP = 32;
  localparam int AW  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0, rsta_n = 1'b1, rstb_n = 1'b1;
  logic          ce_a = 1'b0, we_a = 1'b0, ce_b = 1'b0, we_b = 1'b0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic [DW-1:0] wd_a = '0, wd_b = '0;
  logic [DW-1:0] q0a, q0b, q1a, q1b;

  // model: u_dut = A normal / B read-first, u_dut_wt = both write-through
  logic [DW-1:0] m_mem [DEP];
  logic [DW-1:0] e0a = '0, e0b = '0, e1a = '0, e1b = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dpram_wm #(.DW(DW), .DEPTH(DEP), .MODE_A(WM_NORMAL), .MODE_B(WM_READ_FIRST)) u_dut (
    .rst_ni(rst_n),
    .clk_a_i(clk), .rst_a_ni(rsta_n), .ce_a_i(ce_a), .we_a_i(we_a),
    .addr_a_i(addr_a), .wdata_a_i(wd_a), .rdata_a_o(q0a),
    .clk_b_i(clk), .rst_b_ni(rstb_n), .ce_b_i(ce_b), .we_b_i(we_b),
    .addr_b_i(addr_b), .wdata_b_i(wd_b), .rdata_b_o(q0b)
  );

  dpram_wm #(.DW(DW), .DEPTH(DEP), .MODE_A(WM_THROUGH), .MODE_B(WM_THROUGH)) u_dut_wt (
    .rst_ni(rst_n),
    .clk_a_i(clk), .rst_a_ni(rsta_n), .ce_a_i(ce_a), .we_a_i(we_a),
    .addr_a_i(addr_a), .wdata_a_i(wd_a), .rdata_a_o(q1a),
    .clk_b_i(clk), .rst_b_ni(rstb_n), .ce_b_i(ce_b), .we_b_i(we_b),
    .addr_b_i(addr_b), .wdata_b_i(wd_b), .rdata_b_o(q1b)
  );

  task automatic cmp(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all(string tag);
    cmp(tag, "normal A", q0a, e0a);
    cmp(tag, "read-first B", q0b, e0b);
    cmp(tag, "through A", q1a, e1a);
    cmp(tag, "through B", q1b, e1b);
  endtask

  // one clock edge: update the model from the inputs, then check at the falling edge
  task automatic cyc(string tag);
    logic [DW-1:0] olda, oldb;
    @(posedge clk);
    olda = m_mem[addr_a];
    oldb = m_mem[addr_b];
    if (rst_n && rsta_n && ce_a) begin
      if (!we_a) e0a = olda;
      e1a = we_a ? wd_a : olda;
    end
    if (rst_n && rstb_n && ce_b) begin
      e0b = oldb;
      e1b = we_b ? wd_b : oldb;
    end
    if (ce_a && we_a) m_mem[addr_a] = wd_a;
    if (ce_b && we_b) m_mem[addr_b] = wd_b;
    @(negedge clk);
    cmp_all(tag);
  endtask

  task automatic set_a(logic ce, logic we, int adr, logic [DW-1:0] d);
    ce_a = ce; we_a = we; addr_a = AW'(adr); wd_a = d;
  endtask

  task automatic set_b(logic ce, logic we, int adr, logic [DW-1:0] d);
    ce_b = ce; we_b = we; addr_b = AW'(adr); wd_b = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: outputs zero while the global reset is held
    repeat (3) @(negedge clk);
    cmp_all("R8");
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all("R8");

    // R6: fill through both ports, then read each word from the opposite port
    for (int i = 0; i < DEP / 2; i++) begin
      set_a(1, 1, 2 * i, DW'(18'h1000 + 37 * i));
      set_b(1, 1, 2 * i + 1, DW'(18'h2F000 + 53 * i));
      cyc("R6");
    end
    for (int i = 0; i < DEP; i++) begin
      set_a(1, 0, i ^ 1, '0);
      set_b(1, 0, i, '0);
      cyc("R6");
    end

    // R1 R2 R3 R4: write cycles on both ports (width 18 accepts read-first)
    set_a(1, 1, 3, 18'h2AAAA);
    set_b(1, 1, 12, 18'h15555);
    cyc("R1/R2/R3/R4");
    set_a(1, 1, 5, 18'h0F0F0);
    set_b(1, 1, 3, 18'h3C3C3);
    cyc("R1/R2/R3");
    set_a(1, 0, 12, '0);
    set_b(1, 0, 5, '0);
    cyc("R1/R3");
    set_a(1, 0, 3, '0);
    set_b(1, 0, 3, '0);
    cyc("R6");

    // R5: enables low with writes requested change nothing
    set_a(0, 1, 20, 18'h3FFFF);
    set_b(0, 1, 21, 18'h11111);
    cyc("R5");
    cyc("R5");
    set_a(1, 0, 21, '0);
    set_b(1, 0, 20, '0);
    cyc("R5");

    // R7: port A reset clears A at once, B untouched
    set_a(1, 0, 7, '0);
    set_b(1, 0, 8, '0);
    rsta_n = 1'b0;
    #1;
    e0a = '0; e1a = '0;
    cmp_all("R7");
    cyc("R7");
    rsta_n = 1'b1;
    cyc("R9");
    // R7: port B reset
    set_a(1, 0, 9, '0);
    set_b(1, 0, 10, '0);
    cyc("R7");
    rstb_n = 1'b0;
    #1;
    e0b = '0; e1b = '0;
    cmp_all("R7");
    rstb_n = 1'b1;
    cyc("R9");

    // R8 R9: global reset clears both, memory survives
    rst_n = 1'b0;
    #1;
    e0a = '0; e0b = '0; e1a = '0; e1b = '0;
    cmp_all("R8");
    set_a(0, 0, 0, '0);
    set_b(0, 0, 0, '0);
    cyc("R8");
    rst_n = 1'b1;
    for (int i = 0; i < DEP; i++) begin
      set_a(1, 0, i, '0);
      set_b(1, 0, DEP - 1 - i, '0);
      cyc("R9");
    end

    // R6 with mixed traffic on both ports, no same-address collisions
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] aa, ab;
      aa = AW'($urandom);
      ab = AW'($urandom);
      set_a(logic'($urandom_range(0, 3) != 0), logic'($urandom), int'(aa), DW'($urandom));
      if (ab == aa) ab = aa ^ AW'(1);
      set_b(logic'($urandom_range(0, 3) != 0), logic'($urandom), int'(ab), DW'($urandom));
      cyc("R6");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule